// File: doc/BRIEF.md
# Little-Endian Memory Bus Bridge

This block connects a 16-bit processor core to a flat 64 KB physical address space. The core issues byte or word read and write requests with a 16-bit byte address and a valid/ready handshake. There is no address translation: the physical address is the address the core supplies.

The bridge places bytes on lanes in little-endian order, so the even byte of a word is the low byte. It sends every access in the top 4 KB page (0xF000 to 0xFFFF) to a device-register port and every other access to a RAM port. Each port has its own valid/ready handshake, and either port may hold ready low to insert wait states.

A word access to an odd address is not split into two accesses. Instead, the bridge raises an alignment trap for one cycle and makes no transfer on either port. The core sees the result of a completed access as a one-cycle response strobe that carries the read data.

Top module: `mem_lane_bridge`

## Requirements
- R1: After reset, `req_ready` is 1 and `rsp_valid`, `align_trap`, `ram_valid` and `dev_valid` are all 0.
- R2: Memory is little-endian. A word written at an even address A puts bits [7:0] at byte A and bits [15:8] at byte A+1. Byte reads of A and A+1 return those bytes.
- R3: Byte enables are lane 0 (bit 0) for data bits [7:0] and lane 1 (bit 1) for data bits [15:8]. A word access drives 2'b11. A byte access to an even address drives 2'b01, and a byte access to an odd address drives 2'b10. A byte write copies the write byte onto both lanes, so the byte in the other lane is left unchanged.
- R4: A byte read returns the selected byte in `rsp_rdata[7:0]`, with `rsp_rdata[15:8]` equal to zero.
- R5: An access whose address bits [15:12] are all ones goes only to the device port, with `dev_addr` equal to address bits [11:0] with bit 0 cleared. Any other access goes only to the RAM port, with `ram_addr` equal to the address with bit 0 cleared. The two port valids are never high together.
- R6: A word access to an odd address raises `align_trap` for exactly one cycle, starting on the clock edge that accepts the request. It makes no transfer on either port and produces no `rsp_valid`.
- R7: A byte access to an odd address is legal and raises no trap.
- R8: The access completes one cycle after the selected port's handshake. With W wait states, `rsp_valid` appears W+2 cycles after acceptance. While an access is outstanding, `req_ready` is 0 and the port's address stays stable.
- R9: `rsp_valid` is a one-cycle pulse for each completed access, reads and writes alike.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Core request valid |
| req_ready | output | 1 | Bridge can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_byte | input | 1 | 1 = byte access, 0 = word access |
| req_addr | input | 16 | Byte address |
| req_wdata | input | 16 | Write data; a byte write uses bits [7:0] |
| rsp_valid | output | 1 | One-cycle completion strobe |
| rsp_rdata | output | 16 | Read data; a byte read is zero-extended |
| align_trap | output | 1 | One-cycle trap for a misaligned word access |
| ram_valid | output | 1 | RAM request valid |
| ram_ready | input | 1 | RAM ready; may be held low to insert wait states |
| ram_write | output | 1 | RAM write strobe qualifier |
| ram_addr | output | 16 | RAM word address (bit 0 is 0) |
| ram_be | output | 2 | RAM byte-lane enables |
| ram_wdata | output | 16 | RAM write data, with lanes steered |
| ram_rdata | input | 16 | RAM read data |
| dev_valid | output | 1 | Device request valid |
| dev_ready | input | 1 | Device ready; may be held low to insert wait states |
| dev_write | output | 1 | Device write strobe qualifier |
| dev_addr | output | 12 | Offset within the device page (bit 0 is 0) |
| dev_be | output | 2 | Device byte-lane enables |
| dev_wdata | output | 16 | Device write data, with lanes steered |
| dev_rdata | input | 16 | Device read data |

## Verification
The lane and port choices are stored when a request is accepted. A stored lane choice that is wrong shows up as a corrupted neighbour byte, which the next word read-back catches. A stored port choice that is wrong shows up as a handshake on the other port within the same access. A busy flag that is stuck or cleared early shows up as `req_ready` high during wait states, or as a latency that differs from W+2, so the bench measures latency on every access. A trap path that leaks shows up as a port handshake or a response strobe in the cycle after the trap.

// File: rtl/mem_lane_bridge.sv
module mem_lane_bridge #(
  parameter int ADDR_W    = 16,
  parameter int IO_PAGE_W = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_write,
  input  logic                 req_byte,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [15:0]          req_wdata,
  output logic                 rsp_valid,
  output logic [15:0]          rsp_rdata,
  output logic                 align_trap,
  output logic                 ram_valid,
  input  logic                 ram_ready,
  output logic                 ram_write,
  output logic [ADDR_W-1:0]    ram_addr,
  output logic [1:0]           ram_be,
  output logic [15:0]          ram_wdata,
  input  logic [15:0]          ram_rdata,
  output logic                 dev_valid,
  input  logic                 dev_ready,
  output logic                 dev_write,
  output logic [IO_PAGE_W-1:0] dev_addr,
  output logic [1:0]           dev_be,
  output logic [15:0]          dev_wdata,
  input  logic [15:0]          dev_rdata
);
  localparam int LANE_W = 8;
  localparam int PAGE_TAG_W = ADDR_W - IO_PAGE_W;

  logic              busy;
  logic              io_q, wr_q, byte_q, odd_q;
  logic [ADDR_W-1:0] addr_q;
  logic [1:0]        be_q;
  logic [15:0]       wlanes_q;

  logic accept, misaligned, io_hit, sel_ready;
  logic [15:0] sel_rdata, steered;
  logic [1:0]  be_next;
  logic [15:0] wlanes_next;

  assign req_ready  = ~busy;
  assign accept     = req_valid & ~busy;
  assign misaligned = ~req_byte & req_addr[0];
  assign io_hit     = &req_addr[ADDR_W-1 -: PAGE_TAG_W];

  assign be_next     = req_byte ? (req_addr[0] ? 2'b10 : 2'b01) : 2'b11;
  assign wlanes_next = req_byte ? {2{req_wdata[LANE_W-1:0]}} : req_wdata;

  assign sel_ready = io_q ? dev_ready : ram_ready;
  assign sel_rdata = io_q ? dev_rdata : ram_rdata;
  assign steered   = !byte_q ? sel_rdata :
                     {{LANE_W{1'b0}}, odd_q ? sel_rdata[15:LANE_W] : sel_rdata[LANE_W-1:0]};

  assign ram_valid = busy & ~io_q;
  assign ram_write = wr_q;
  assign ram_addr  = {addr_q[ADDR_W-1:1], 1'b0};
  assign ram_be    = be_q;
  assign ram_wdata = wlanes_q;

  assign dev_valid = busy & io_q;
  assign dev_write = wr_q;
  assign dev_addr  = {addr_q[IO_PAGE_W-1:1], 1'b0};
  assign dev_be    = be_q;
  assign dev_wdata = wlanes_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      align_trap <= 1'b0;
      rsp_valid  <= 1'b0;
      rsp_rdata  <= '0;
      io_q       <= 1'b0;
      wr_q       <= 1'b0;
      byte_q     <= 1'b0;
      odd_q      <= 1'b0;
      addr_q     <= '0;
      be_q       <= '0;
      wlanes_q   <= '0;
    end else begin
      align_trap <= accept & misaligned;
      rsp_valid  <= 1'b0;
      if (accept && !misaligned) begin
        busy     <= 1'b1;
        io_q     <= io_hit;
        wr_q     <= req_write;
        byte_q   <= req_byte;
        odd_q    <= req_addr[0];
        addr_q   <= req_addr;
        be_q     <= be_next;
        wlanes_q <= wlanes_next;
      end else if (busy && sel_ready) begin
        busy      <= 1'b0;
        rsp_valid <= 1'b1;
        rsp_rdata <= wr_q ? 16'h0000 : steered;
      end
    end
  end
endmodule

// File: rtl/mem_lane_bridge_chk.sv
module mem_lane_bridge_chk #(
  parameter int ADDR_W    = 16,
  parameter int IO_PAGE_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              align_trap,
  input logic              ram_valid,
  input logic              ram_ready,
  input logic [ADDR_W-1:0] ram_addr,
  input logic [1:0]        ram_be,
  input logic              dev_valid,
  input logic              dev_ready,
  input logic [IO_PAGE_W-1:0] dev_addr,
  input logic [1:0]        dev_be
);
  AST_ONE_PORT:      assert property (@(posedge clk) disable iff (!rst_n) !(ram_valid && dev_valid)); // R5
  AST_TRAP_PULSE:    assert property (@(posedge clk) disable iff (!rst_n) align_trap |=> !align_trap); // R6
  AST_TRAP_NO_XFER:  assert property (@(posedge clk) disable iff (!rst_n) align_trap |-> !ram_valid && !dev_valid && !rsp_valid); // R6
  AST_BUSY_BLOCKS:   assert property (@(posedge clk) disable iff (!rst_n) (ram_valid || dev_valid) |-> !req_ready); // R8
  AST_RAM_HOLD:      assert property (@(posedge clk) disable iff (!rst_n) ram_valid && !ram_ready |=> ram_valid && $stable(ram_addr) && $stable(ram_be)); // R8
  AST_DEV_HOLD:      assert property (@(posedge clk) disable iff (!rst_n) dev_valid && !dev_ready |=> dev_valid && $stable(dev_addr) && $stable(dev_be)); // R8
  AST_RSP_PULSE:     assert property (@(posedge clk) disable iff (!rst_n) rsp_valid |=> !rsp_valid); // R9
  AST_BE_LEGAL:      assert property (@(posedge clk) disable iff (!rst_n) ram_valid |-> ram_be != 2'b00); // R3
  AST_RAM_EVEN:      assert property (@(posedge clk) disable iff (!rst_n) ram_valid |-> !ram_addr[0]); // R5
endmodule

bind mem_lane_bridge mem_lane_bridge_chk #(.ADDR_W(ADDR_W), .IO_PAGE_W(IO_PAGE_W)) chk_i (.*);

// File: tb/mem_lane_bridge_tb_top.sv
`timescale 1ns/1ps
module mem_lane_bridge_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic req_valid = 0, req_write = 0, req_byte = 0;
  logic [15:0] req_addr = 0, req_wdata = 0;
  logic req_ready, rsp_valid, align_trap;
  logic [15:0] rsp_rdata;
  logic ram_valid, ram_ready, ram_write, dev_valid, dev_ready, dev_write;
  logic [15:0] ram_addr, ram_wdata, ram_rdata, dev_wdata, dev_rdata;
  logic [11:0] dev_addr;
  logic [1:0] ram_be, dev_be;

  mem_lane_bridge dut_i (.*);

  logic [15:0] ram_mem [0:63];
  logic [15:0] dev_mem [0:63];
  int ram_wait = 0, dev_wait = 0;
  int ram_cnt = 0, dev_cnt = 0;
  int ram_xfers = 0, dev_xfers = 0;
  logic [1:0] last_ram_be = 0;
  logic [11:0] last_dev_addr = 0;
  logic [15:0] last_ram_addr = 0;

  assign ram_ready = ram_valid && (ram_cnt >= ram_wait);
  assign dev_ready = dev_valid && (dev_cnt >= dev_wait);
  assign ram_rdata = ram_mem[ram_addr[6:1]];
  assign dev_rdata = dev_mem[dev_addr[6:1]];

  always @(posedge clk) begin
    ram_cnt <= (!ram_valid || ram_ready) ? 0 : ram_cnt + 1;
    dev_cnt <= (!dev_valid || dev_ready) ? 0 : dev_cnt + 1;
    if (ram_valid && ram_ready) begin
      ram_xfers <= ram_xfers + 1;
      last_ram_be <= ram_be;
      last_ram_addr <= ram_addr;
      if (ram_write) begin
        if (ram_be[0]) ram_mem[ram_addr[6:1]][7:0]  <= ram_wdata[7:0];
        if (ram_be[1]) ram_mem[ram_addr[6:1]][15:8] <= ram_wdata[15:8];
      end
    end
    if (dev_valid && dev_ready) begin
      dev_xfers <= dev_xfers + 1;
      last_dev_addr <= dev_addr;
      if (dev_write) begin
        if (dev_be[0]) dev_mem[dev_addr[6:1]][7:0]  <= dev_wdata[7:0];
        if (dev_be[1]) dev_mem[dev_addr[6:1]][15:8] <= dev_wdata[15:8];
      end
    end
  end

  int checks = 0, errors = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic xfer(input bit wr, input bit by, input logic [15:0] a, input logic [15:0] wd,
                      output logic [15:0] rd, output bit trapped, output int lat, output bit ready_leak);
    trapped = 0; ready_leak = 0; lat = 0; rd = 'x;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_byte = by; req_addr = a; req_wdata = wd;
    @(negedge clk);
    req_valid = 0;
    lat = 1;
    for (int i = 0; i < 60; i++) begin
      if (align_trap) begin trapped = 1; break; end
      if (rsp_valid) begin rd = rsp_rdata; break; end
      if (req_ready) ready_leak = 1;
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic t_reset();
    check("R1 req_ready", req_ready, 1);
    check("R1 rsp_valid", rsp_valid, 0);
    check("R1 align_trap", align_trap, 0);
    check("R1 port valids", {ram_valid, dev_valid}, 0);
  endtask

  task automatic t_little_endian();
    logic [15:0] rd; bit tr, lk; int lat;
    xfer(1, 0, 16'h0010, 16'hBEEF, rd, tr, lat, lk);
    check("R3 word be", last_ram_be, 2'b11);
    check("R9 write rsp pulse", rsp_valid, 1);
    @(negedge clk);
    check("R9 rsp drops", rsp_valid, 0);
    xfer(0, 1, 16'h0010, 0, rd, tr, lat, lk);
    check("R2 low byte at even", rd, 16'h00EF);
    check("R3 even byte be", last_ram_be, 2'b01);
    xfer(0, 1, 16'h0011, 0, rd, tr, lat, lk);
    check("R2 R4 high byte at odd", rd, 16'h00BE);
    check("R7 no trap odd byte", tr, 0);
    check("R3 odd byte be", last_ram_be, 2'b10);
    xfer(0, 0, 16'h0010, 0, rd, tr, lat, lk);
    check("R2 word read", rd, 16'hBEEF);
  endtask

  task automatic t_byte_writes();
    logic [15:0] rd; bit tr, lk; int lat;
    xfer(1, 0, 16'h0012, 16'h1122, rd, tr, lat, lk);
    xfer(1, 1, 16'h0013, 16'h00A5, rd, tr, lat, lk);
    check("R7 odd byte write no trap", tr, 0);
    xfer(0, 0, 16'h0012, 0, rd, tr, lat, lk);
    check("R3 odd byte write keeps low", rd, 16'hA522);
    xfer(1, 1, 16'h0012, 16'hFF3C, rd, tr, lat, lk);
    xfer(0, 0, 16'h0012, 0, rd, tr, lat, lk);
    check("R3 even byte write keeps high", rd, 16'hA53C);
    xfer(0, 1, 16'h0013, 0, rd, tr, lat, lk);
    check("R4 zero extend", rd, 16'h00A5);
  endtask

  task automatic t_decode();
    logic [15:0] rd; bit tr, lk; int lat; int r0, d0;
    r0 = ram_xfers; d0 = dev_xfers;
    xfer(1, 0, 16'hEFFE, 16'h5A5A, rd, tr, lat, lk);
    check("R5 0xEFFE to ram", {ram_xfers - r0, dev_xfers - d0}, {32'd1, 32'd0});
    check("R5 ram addr", last_ram_addr, 16'hEFFE);
    r0 = ram_xfers; d0 = dev_xfers;
    xfer(1, 0, 16'hF004, 16'h1234, rd, tr, lat, lk);
    check("R5 0xF004 to dev", {ram_xfers - r0, dev_xfers - d0}, {32'd0, 32'd1});
    check("R5 dev offset", last_dev_addr, 12'h004);
    check("R5 dev data", dev_mem[2], 16'h1234);
    xfer(0, 1, 16'hF005, 0, rd, tr, lat, lk);
    check("R5 R4 dev byte read", rd, 16'h0012);
    xfer(0, 0, 16'hEFFE, 0, rd, tr, lat, lk);
    check("R5 ram unaffected by dev", rd, 16'h5A5A);
  endtask

  task automatic t_trap();
    logic [15:0] rd; bit tr, lk; int lat; int r0, d0;
    r0 = ram_xfers; d0 = dev_xfers;
    xfer(1, 0, 16'h0011, 16'hDEAD, rd, tr, lat, lk);
    check("R6 trap raised", tr, 1);
    check("R6 trap latency", lat, 1);
    check("R6 no rsp", rsp_valid, 0);
    @(negedge clk);
    check("R6 trap one cycle", align_trap, 0);
    check("R6 no rsp after", rsp_valid, 0);
    check("R6 no transfer", {ram_xfers - r0, dev_xfers - d0}, 64'd0);
    xfer(0, 0, 16'hF003, 0, rd, tr, lat, lk);
    check("R6 dev misaligned trap", tr, 1);
    @(negedge clk);
    check("R6 no dev transfer", dev_xfers - d0, 0);
    xfer(0, 0, 16'h0012, 0, rd, tr, lat, lk);
    check("R6 memory intact", rd, 16'hA53C);
  endtask

  task automatic t_waits();
    logic [15:0] rd; bit tr, lk; int lat;
    for (int w = 0; w < 4; w++) begin
      ram_wait = w;
      xfer(0, 0, 16'h0010, 0, rd, tr, lat, lk);
      check("R8 ram latency", lat, w + 2);
      check("R8 ready low while busy", lk, 0);
      check("R8 data with waits", rd, 16'hBEEF);
    end
    ram_wait = 0;
    dev_wait = 3;
    xfer(0, 0, 16'hF004, 0, rd, tr, lat, lk);
    check("R8 dev latency", lat, 5);
    check("R8 dev ready low while busy", lk, 0);
    dev_wait = 0;
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin ram_mem[i] = 0; dev_mem[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_little_endian();
    t_byte_writes();
    t_decode();
    t_trap();
    t_waits();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule